// File: doc/BRIEF.md
# Zero-Limited Pseudorandom Pattern Generator

This block produces a serial pseudorandom test stream for line and link testing. A pattern select picks one of six maximal-length shift registers with 6, 9, 11, 15, 20 or 23 stages. The chosen register produces a sequence of 2^n-1 bits before it repeats. A seventh setting runs the 20-stage register through a zero-run limiter. The limiter forces a one onto the line whenever fourteen zeros in a row have already gone out. This caps the zero runs that a line-coded facility has to carry. The register underneath keeps stepping untouched, so the period stays at 1,048,575 bits.

Each cycle in which the bit-enable is high advances the stream by one bit. A synchronous restart reloads an all-ones seed, which keeps the register out of the all-zeros lock-up state. An invert control complements the bit on the wire. An end-of-sequence strobe marks the last bit of every period, so a receiver or a test controller can count whole periods.

Top module: `prbs_qrss_gen`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released until the first enabled step, `bit_o` and `eos_o` are 0.
- R2: The select codes map to register lengths n and feedback positions k as follows: 0 gives n=6, k=5; 1 gives n=9, k=5; 2 gives n=11, k=9; 3 gives n=15, k=14; 4 gives n=20, k=17; 5 gives n=23, k=18; 6 and 7 give the limited 20-stage mode. The raw bit sequence follows b[t+n] = b[t] XOR b[t+n-k].
- R3: After a restart, the first n raw bits are all ones (the seed).
- R4: The raw sequence repeats every 2^n-1 enabled steps. `eos_o` is high for exactly one clock, on the step that emits the last bit of each period.
- R5: In a cycle with `en_i` low and no restart, the sequence does not advance, `bit_o` holds its value and `eos_o` is 0.
- R6: Restart takes priority over enable. In the cycle after a restart, `bit_o` and `eos_o` are 0, and the next enabled step emits the first bit of a new period.
- R7: In the limited mode, no more than ZRUN_MAX (default 14) consecutive zeros are emitted. The bit that follows ZRUN_MAX emitted zeros is forced to one.
- R8: Forcing does not alter the register. The limited mode emits the raw 20-stage bit except where a one is forced, and it keeps the 1,048,575-bit period and its strobe.
- R9: The limiter's zero count covers emitted bits only and restarts at zero after any emitted one, forced or raw.
- R10: When `inv_i` is high on an enabled step, the emitted bit is complemented on `bit_o`. The limiter and `eos_o` are unaffected.
- R11: Outside the limited mode no bit is forced. Over one period, the longest zero run is n-1 and the longest one run is n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bit-enable: advance one bit |
| restart_i | input | 1 | Synchronous restart, reloads the seed |
| sel_i | input | 3 | Pattern select (codes in R2) |
| inv_i | input | 1 | Complement the emitted bit |
| bit_o | output | 1 | Serial pattern bit, registered |
| eos_o | output | 1 | One-clock strobe on the last bit of a period |

## Verification
The bench builds two copies side by side. One uses the default zero limit of 14. The other uses a limit of 3, which makes forced ones frequent enough to exercise the limiter's count-clearing and its independence from the register within a short window. Full periods, together with their longest zero and one runs, are within reach for the 6, 9, 11 and 15-stage settings. The 20-stage, 23-stage and limited settings are compared bit by bit over windows of tens of thousands of steps, with random enable gaps, inversion toggles and a mid-run restart.

// File: rtl/prbsgen_pkg.sv
package prbsgen_pkg;
  localparam int STAGES_MAX = 23;
  localparam int SEL_W      = 3;
  localparam int POLY_W     = 3;
  localparam int POLY_SLOTS = 1 << POLY_W;
  localparam int LIMIT_POLY = 4;

  typedef enum logic [SEL_W-1:0] {
    PAT_N6     = 3'd0,
    PAT_N9     = 3'd1,
    PAT_N11    = 3'd2,
    PAT_N15    = 3'd3,
    PAT_N20    = 3'd4,
    PAT_N23    = 3'd5,
    PAT_LIM    = 3'd6,
    PAT_LIM_B  = 3'd7
  } pat_sel_e;

  // Register length per polynomial slot.
  function automatic int poly_len(input int idx);
    case (idx)
      0:       return 6;
      1:       return 9;
      2:       return 11;
      3:       return 15;
      4:       return 20;
      default: return 23;
    endcase
  endfunction

  // Second feedback stage per polynomial slot.
  function automatic int poly_tap(input int idx);
    case (idx)
      0:       return 5;
      1:       return 5;
      2:       return 9;
      3:       return 14;
      4:       return 17;
      default: return 18;
    endcase
  endfunction

  function automatic logic sel_limited(input logic [SEL_W-1:0] sel);
    return (sel == PAT_LIM) || (sel == PAT_LIM_B);
  endfunction

  function automatic logic [POLY_W-1:0] sel_poly(input logic [SEL_W-1:0] sel);
    if (sel_limited(sel)) return POLY_W'(LIMIT_POLY);
    return POLY_W'(sel);
  endfunction
endpackage

// File: rtl/prbs_shift_core.sv
module prbs_shift_core
  import prbsgen_pkg::*;
#(
  parameter int W = STAGES_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [POLY_W-1:0] poly_i,
  output logic              raw_bit_o,
  output logic              wrap_o
);
  logic [W-1:0] st_q, st_d, adv;
  logic [W-1:0] seed;
  logic [POLY_SLOTS-1:0] fb_vec, out_vec;
  logic [W-1:0] mask_tab [POLY_SLOTS];
  logic fb;

  for (genvar m = 0; m < POLY_SLOTS; m++) begin : g_poly
    localparam int LEN = poly_len(m);
    localparam int TAP = poly_tap(m);
    assign fb_vec[m]   = st_q[LEN-1] ^ st_q[TAP-1];
    assign out_vec[m]  = st_q[LEN-1];
    assign mask_tab[m] = W'((64'd1 << LEN) - 64'd1);
  end

  always_comb begin
    seed      = mask_tab[poly_i];
    fb        = fb_vec[poly_i];
    raw_bit_o = out_vec[poly_i];
    adv       = {st_q[W-2:0], fb} & seed;
    wrap_o    = (adv == seed);
    st_d      = st_q;
    if (restart_i)   st_d = seed;
    else if (step_i) st_d = adv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else         st_q <= st_d;
  end

  // R3: restart leaves exactly the seed of the selected length
  a_r3_seed_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (st_q == $past(seed)));
endmodule

// File: rtl/prbs_zero_limiter.sv
module prbs_zero_limiter #(
  parameter int ZRUN_MAX = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic restart_i,
  input  logic limit_en_i,
  input  logic raw_bit_i,
  output logic emit_bit_o
);
  localparam int CW = (ZRUN_MAX < 2) ? 1 : $clog2(ZRUN_MAX + 1);

  logic [CW-1:0] zcnt_q, zcnt_d;
  logic          full;

  always_comb begin
    full       = (zcnt_q == CW'(ZRUN_MAX));
    emit_bit_o = raw_bit_i | (limit_en_i & full);
    zcnt_d     = zcnt_q;
    if (restart_i)        zcnt_d = '0;
    else if (step_i) begin
      if (emit_bit_o)     zcnt_d = '0;
      else if (!full)     zcnt_d = zcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zcnt_q <= '0;
    else         zcnt_q <= zcnt_d;
  end

  // R9: any emitted one, forced or not, empties the zero count
  a_r9_clear_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && emit_bit_o) |=> (zcnt_q == '0));
endmodule

// File: rtl/prbs_qrss_gen.sv
module prbs_qrss_gen
  import prbsgen_pkg::*;
#(
  parameter int ZRUN_MAX = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             bit_o,
  output logic             eos_o
);
  localparam int CHK_W = $clog2(ZRUN_MAX + 2) + 1;

  logic [POLY_W-1:0] poly;
  logic              limited, raw_bit, wrap, emit_bit;
  logic              bit_q, bit_d, eos_q, eos_d;

  assign poly    = sel_poly(sel_i);
  assign limited = sel_limited(sel_i);

  prbs_shift_core #(.W(STAGES_MAX)) core_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (en_i),
    .restart_i (restart_i),
    .poly_i    (poly),
    .raw_bit_o (raw_bit),
    .wrap_o    (wrap)
  );

  prbs_zero_limiter #(.ZRUN_MAX(ZRUN_MAX)) lim_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (en_i),
    .restart_i  (restart_i),
    .limit_en_i (limited),
    .raw_bit_i  (raw_bit),
    .emit_bit_o (emit_bit)
  );

  always_comb begin
    bit_d = bit_q;
    eos_d = 1'b0;
    if (restart_i) begin
      bit_d = 1'b0;
    end else if (en_i) begin
      bit_d = emit_bit ^ inv_i;
      eos_d = wrap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      eos_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      eos_q <= eos_d;
    end
  end

  assign bit_o = bit_q;
  assign eos_o = eos_q;

  // Independent run counter over emitted bits in the limited mode
  logic [CHK_W-1:0] chk_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         chk_run_q <= '0;
    else if (restart_i || !limited)      chk_run_q <= '0;
    else if (en_i && emit_bit)           chk_run_q <= '0;
    else if (en_i && chk_run_q != '1)    chk_run_q <= chk_run_q + CHK_W'(1);
  end

  a_r7_zero_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_run_q <= CHK_W'(ZRUN_MAX));

  a_r4_eos_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !en_i) |=> ($stable(bit_o) && !eos_o));

  a_r6_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!bit_o && !eos_o));
endmodule

// File: tb/prbs_qrss_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_qrss_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       restart_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       inv_i = 1'b0;
  logic       bit_a, eos_a, bit_b, eos_b;

  always #2.5 clk_i = ~clk_i;

  prbs_qrss_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .restart_i(restart_i),
    .sel_i(sel_i), .inv_i(inv_i), .bit_o(bit_a), .eos_o(eos_a));

  prbs_qrss_gen #(.ZRUN_MAX(3)) dut_lim_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .restart_i(restart_i),
    .sel_i(sel_i), .inv_i(inv_i), .bit_o(bit_b), .eos_o(eos_b));

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int hist[$];
  int n_len, k_tap, period, pos;
  bit limited;
  int zr_a, zr_b, forced_b;
  bit exp_a, exp_b, exp_eos;
  int eos_seen, ones_head, cur_z, cur_o, max_z, max_o, emitted;

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void load_params(input logic [2:0] s);
    limited = (s >= 3'd6);
    case (limited ? 3'd4 : s)
      3'd0: begin n_len = 6;  k_tap = 5;  end
      3'd1: begin n_len = 9;  k_tap = 5;  end
      3'd2: begin n_len = 11; k_tap = 9;  end
      3'd3: begin n_len = 15; k_tap = 14; end
      3'd4: begin n_len = 20; k_tap = 17; end
      default: begin n_len = 23; k_tap = 18; end
    endcase
    period = (1 << n_len) - 1;
  endfunction

  function automatic void model_edge(input bit en, input bit rs, input bit inv);
    int raw, nb;
    bit ea, eb;
    if (rs) begin
      load_params(sel_i);
      hist.delete();
      for (int i = 0; i < n_len; i++) hist.push_back(1);
      pos = 0; zr_a = 0; zr_b = 0;
      exp_a = 0; exp_b = 0; exp_eos = 0;
      eos_seen = 0; ones_head = 0; emitted = 0;
      cur_z = 0; cur_o = 0; max_z = 0; max_o = 0;
    end else if (en) begin
      raw = hist[0];
      nb = hist[0] ^ hist[n_len - k_tap];
      void'(hist.pop_front());
      hist.push_back(nb);
      ea = (raw != 0) || (limited && zr_a >= 14);
      eb = (raw != 0) || (limited && zr_b >= 3);
      if (eb && raw == 0) forced_b++;
      zr_a = ea ? 0 : (zr_a < 14 ? zr_a + 1 : 14);
      zr_b = eb ? 0 : (zr_b < 3 ? zr_b + 1 : 3);
      exp_a = ea ^ inv;
      exp_b = eb ^ inv;
      exp_eos = (pos == period - 1);
      pos = (pos + 1 == period) ? 0 : pos + 1;
      if (exp_eos) eos_seen++;
      if (emitted < n_len && ea) ones_head++;
      emitted++;
      if (ea) begin cur_o++; cur_z = 0; end
      else    begin cur_z++; cur_o = 0; end
      if (cur_o > max_o) max_o = cur_o;
      if (cur_z > max_z) max_z = cur_z;
    end else begin
      exp_eos = 0;
    end
  endfunction

  // one clock: drive at negedge, compare both copies after the edge
  task automatic step(input bit en, input bit rs, input bit inv);
    @(negedge clk_i);
    en_i = en; restart_i = rs; inv_i = inv;
    @(posedge clk_i);
    model_edge(en, rs, inv);
    #1;
    check("R2/R10 bit_o", bit_a, exp_a);
    check("R4 eos_o", eos_a, exp_eos);
    check("R7/R9 bit_o limit3", bit_b, exp_b);
    check("R8 eos_o limit3", eos_b, exp_eos);
  endtask

  task automatic restart_to(input logic [2:0] s);
    @(negedge clk_i);
    sel_i = s;
    step(1'b1, 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    forced_b = 0;
    load_params(3'd0);
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 bit_o in reset", bit_a, 1'b0);
    check("R1 eos_o in reset", eos_a, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    exp_a = 0; exp_b = 0; exp_eos = 0;
    @(posedge clk_i); #1;
    check("R1 bit_o after release", bit_a, 1'b0);
    check("R1 eos_o after release", eos_a, 1'b0);

    // full periods of the four shortest registers
    for (int s = 0; s < 4; s++) begin
      restart_to(3'(s));
      for (int i = 0; i < period; i++) step(1'b1, 1'b0, 1'b0);
      check_int("R3 seed ones at head", ones_head, n_len);
      check_int("R4 strobes per period", eos_seen, 1);
      check_int("R11 longest zero run", max_z, n_len - 1);
      check_int("R11 longest one run", max_o, n_len);
      // random gaps and inversion after the first period
      for (int i = 0; i < 200; i++)
        step(($urandom % 4) != 0, 1'b0, $urandom % 2);
    end

    // restart while enable is also high, then hold with enable low (R5, R6)
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
    check("R6 no bit before first step", bit_a, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R6 first bit after restart is 1", bit_a, 1'b1);

    // long registers, windowed
    restart_to(3'd4);
    for (int i = 0; i < 15000; i++) step(($urandom % 8) != 0, 1'b0, $urandom % 2);
    restart_to(3'd5);
    for (int i = 0; i < 15000; i++) step(($urandom % 8) != 0, 1'b0, $urandom % 2);

    // limited mode, both codes, with a restart in the middle
    restart_to(3'd6);
    for (int i = 0; i < 20000; i++) step(($urandom % 8) != 0, 1'b0, $urandom % 2);
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20000; i++) step(1'b1, 1'b0, 1'b0);
    check_int("R11 default limit not reached in raw head", (max_z <= 14) ? 1 : 0, 1);
    restart_to(3'd7);
    for (int i = 0; i < 3000; i++) step(($urandom % 8) != 0, 1'b0, $urandom % 2);
    check_int("R8 forced ones seen with limit 3", (forced_b > 0) ? 1 : 0, 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule